// File: doc/BRIEF.md
# Time-Slotted Cyclic Memory Controller

This block runs a small memory that has no address inputs. A fixed timing sequence visits every location in turn, so that time itself selects the cell. One-hot rings pick the row and the column. A row ring holds one bit per row, and a column ring holds one bit per column. A single sequencer advances both rings from the system clock. When a row opens, the sequencer waits a programmable row-to-column delay. It then walks the column ring across the row, holding each column for a fixed number of clock cycles. After the last column it opens the next row.

Each column slot ends in an access strobe. An active-low write enable decides the kind of access. When low, it stores the input data in the selected cell. When high, it loads the cell's value into a registered data output. After the final cell of the final row, the sequencer idles for a refresh gap of fixed length and then restarts at row 0 by itself. A full sweep therefore covers ROWS×COLS column slots, and its timing is known ahead of time. A pulse marks the last cell of the last row, so that it can drive the start input of a following device.

Top module: `cyc_seq_mem`

## Requirements
- R1: After reset, row_sel, col_sel, dout and last_row_out are all zero, and they stay zero until start_in is seen high.
- R2: row_sel is one-hot or zero, and bit r means row r. Row 0 opens on the second rising edge after start_in is sampled. Each following row opens one row period (1 + RCD_WAIT + COLS×COL_DIV cycles) later. After the last row, the next row is row 0.
- R3: After a row opens, col_sel stays zero for RCD_WAIT cycles. Column 0 then becomes active, and col_sel never rises with any bit other than bit 0.
- R4: col_sel is one-hot or zero, and bit c means column c. Each column stays active for exactly COL_DIV cycles, in ascending order. The access strobe falls on the last cycle of each column.
- R5: When we_n is low at a strobe, din is stored in cell (row, column), and dout keeps its previous value.
- R6: When we_n is high at a strobe, dout takes the value held in cell (row, column). dout holds that value until the next read strobe.
- R7: last_row_out is high only during the final cycle of the last column of the last row.
- R8: After a sweep, col_sel stays zero and row_sel holds the last row for 2×REF_GAP cycles. The sequencer then reopens row 0 by itself, with no start pulse.
- R9: start_in has no effect while a sweep or a refresh gap is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every ring step is an enable on this clock |
| rst_n | input | 1 | Active-low power-on reset |
| start_in | input | 1 | Kicks off the first sweep from idle |
| we_n | input | 1 | Active-low write select, sampled at each slot strobe |
| din | input | DW | Data stored on a write strobe |
| dout | output | DW | Registered read data |
| row_sel | output | ROWS | One-hot active row |
| col_sel | output | COLS | One-hot active column |
| last_row_out | output | 1 | Marks the final slot of the sweep |

## Verification
The bench drives four sweeps in a row. The first writes a pattern that depends on position into every cell. The second reads everything back. The third alternates writes and reads in a checkerboard. The fourth reads everything again. Together they separate wrong cell indexing, swapped row and column decoding, and writes that disturb dout. At every slot the bench checks row_sel and col_sel against a schedule it computes itself, so a wrong delay, a wrong slot length or a wrong refresh gap shifts the rings away from the expected cycle. A start pulse injected in the middle of the read sweep shows whether the sequencer restarts when it should not.

// File: rtl/cyc_mem_pkg.sv
`timescale 1ns/1ps
package cyc_mem_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW_OPEN,
      ST_RCD,
      ST_COLS,
      ST_REF_INC,
      ST_REF_CMP
   } seq_state_t;

endpackage

// File: rtl/onehot_ring.sv
`timescale 1ns/1ps
module onehot_ring #(
   parameter int LEN = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clear,
   input  logic           load,
   input  logic           step,
   output logic [LEN-1:0] q,
   output logic [((LEN > 1) ? $clog2(LEN) : 1)-1:0] idx
);
   localparam int IW = (LEN > 1) ? $clog2(LEN) : 1;

   generate
      if (LEN < 2) begin : g_len_bad
         $error("onehot_ring needs LEN >= 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (clear)  q <= '0;
      else if (load)   q <= LEN'(1);
      else if (step)   q <= {q[LEN-2:0], q[LEN-1]};
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < LEN; i++) begin
         if (q[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/slot_divider.sv
`timescale 1ns/1ps
module slot_divider #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic slot_end
);
   generate
      if (DIV < 1) begin : g_div_bad
         $error("slot_divider needs DIV >= 1");
      end else if (DIV == 1) begin : g_div_one
         logic unused_sig;
         assign unused_sig = ^{clk, rst_n, restart};
         assign slot_end   = run;
      end else begin : g_div_cnt
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt;
         assign slot_end = run && (cnt == CW'(DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   cnt <= '0;
            else if (restart || slot_end) cnt <= '0;
            else if (run)                 cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/seq_timing_fsm.sv
`timescale 1ns/1ps
module seq_timing_fsm
   import cyc_mem_pkg::*;
#(
   parameter int RCD_WAIT = 2,
   parameter int REF_GAP  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_in,
   input  logic slot_end,
   input  logic last_col,
   input  logic last_row,
   output logic row_step,
   output logic col_load,
   output logic col_run
);
   localparam int WW = $clog2(RCD_WAIT + 1);
   localparam int RW = $clog2(REF_GAP + 1);

   generate
      if (RCD_WAIT < 1 || REF_GAP < 1) begin : g_cfg_bad
         $error("seq_timing_fsm needs RCD_WAIT >= 1 and REF_GAP >= 1");
      end
   endgenerate

   seq_state_t      st, st_nxt;
   logic [WW-1:0]   wcnt;
   logic [RW-1:0]   rcnt;
   logic            rcd_done, ref_done;

   assign rcd_done = (wcnt == WW'(RCD_WAIT - 1));
   assign ref_done = (rcnt >= RW'(REF_GAP));
   assign row_step = (st == ST_ROW_OPEN);
   assign col_load = (st == ST_RCD) && rcd_done;
   assign col_run  = (st == ST_COLS);

   always_comb begin
      st_nxt = st;
      unique case (st)
         ST_IDLE:     if (start_in) st_nxt = ST_ROW_OPEN;
         ST_ROW_OPEN: st_nxt = ST_RCD;
         ST_RCD:      if (rcd_done) st_nxt = ST_COLS;
         ST_COLS:     if (slot_end && last_col)
                         st_nxt = last_row ? ST_REF_INC : ST_ROW_OPEN;
         ST_REF_INC:  st_nxt = ST_REF_CMP;
         ST_REF_CMP:  st_nxt = ref_done ? ST_ROW_OPEN : ST_REF_INC;
         default:     st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         wcnt <= '0;
         rcnt <= '0;
      end else begin
         st <= st_nxt;
         if (st == ST_ROW_OPEN)                 wcnt <= '0;
         else if (st == ST_RCD)                 wcnt <= wcnt + 1'b1;
         if (st == ST_REF_INC)                  rcnt <= rcnt + 1'b1;
         else if (st == ST_REF_CMP && ref_done) rcnt <= '0;
      end
   end
endmodule

// File: rtl/cyc_seq_mem.sv
`timescale 1ns/1ps
module cyc_seq_mem #(
   parameter int ROWS     = 4,
   parameter int COLS     = 4,
   parameter int DW       = 8,
   parameter int RCD_WAIT = 2,
   parameter int COL_DIV  = 2,
   parameter int REF_GAP  = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_in,
   input  logic            we_n,
   input  logic [DW-1:0]   din,
   output logic [DW-1:0]   dout,
   output logic [ROWS-1:0] row_sel,
   output logic [COLS-1:0] col_sel,
   output logic            last_row_out
);
   localparam int DEPTH = ROWS * COLS;
   localparam int AW    = $clog2(DEPTH);
   localparam int RIW   = $clog2(ROWS);
   localparam int CIW   = $clog2(COLS);

   generate
      if (ROWS < 2 || COLS < 2 || DW < 1) begin : g_geom_bad
         $error("cyc_seq_mem needs ROWS >= 2, COLS >= 2, DW >= 1");
      end
   endgenerate

   logic           row_step, col_load, col_run, slot_end;
   logic [RIW-1:0] row_idx;
   logic [CIW-1:0] col_idx;
   logic [AW-1:0]  cell_addr;
   logic [DW-1:0]  cells [DEPTH];

   seq_timing_fsm #(.RCD_WAIT(RCD_WAIT), .REF_GAP(REF_GAP)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_in (start_in),
      .slot_end (slot_end),
      .last_col (col_sel[COLS-1]),
      .last_row (row_sel[ROWS-1]),
      .row_step (row_step),
      .col_load (col_load),
      .col_run  (col_run)
   );

   slot_divider #(.DIV(COL_DIV)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (col_run),
      .restart  (col_load),
      .slot_end (slot_end)
   );

   onehot_ring #(.LEN(ROWS)) u_row_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (1'b0),
      .load  (row_step && !(|row_sel)),
      .step  (row_step),
      .q     (row_sel),
      .idx   (row_idx)
   );

   onehot_ring #(.LEN(COLS)) u_col_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (slot_end && col_sel[COLS-1]),
      .load  (col_load),
      .step  (slot_end),
      .q     (col_sel),
      .idx   (col_idx)
   );

   assign cell_addr    = AW'(row_idx) * AW'(COLS) + AW'(col_idx);
   assign last_row_out = slot_end && col_sel[COLS-1] && row_sel[ROWS-1];

   always_ff @(posedge clk) begin
      if (slot_end && !we_n) cells[cell_addr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                dout <= '0;
      else if (slot_end && we_n) dout <= cells[cell_addr];
   end
endmodule

// File: rtl/cyc_seq_mem_chk.sv
`timescale 1ns/1ps
module cyc_seq_mem_chk #(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   parameter int DW   = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            acc_stb,
   input logic            we_n,
   input logic [DW-1:0]   dout,
   input logic [ROWS-1:0] row_sel,
   input logic [COLS-1:0] col_sel,
   input logic            last_row_out
);
   logic [ROWS-1:0] row_rot;
   logic [COLS-1:0] col_fwd;
   assign row_rot = {row_sel[ROWS-2:0], row_sel[ROWS-1]};
   assign col_fwd = col_sel << 1;

   assert_row_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_sel));

   assert_row_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|row_sel) |=> (row_sel == $past(row_sel)) || (row_sel == $past(row_rot)));

   assert_col_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col_sel));

   assert_col_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|col_sel) |=> (col_sel == $past(col_sel)) || (col_sel == $past(col_fwd)) || (col_sel == '0));

   assert_strobe_in_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      acc_stb |-> (|col_sel) && (|row_sel));

   assert_col_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|col_sel) |-> col_sel[0]);

   assert_col_needs_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|col_sel) |-> (|row_sel));

   assert_dout_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_stb && we_n) |=> $stable(dout));

   assert_last_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
      last_row_out |-> row_sel[ROWS-1] && col_sel[COLS-1] && acc_stb);
endmodule

bind cyc_seq_mem cyc_seq_mem_chk #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_stb      (slot_end),
   .we_n         (we_n),
   .dout         (dout),
   .row_sel      (row_sel),
   .col_sel      (col_sel),
   .last_row_out (last_row_out)
);

// File: tb/sim_cyc_seq_mem.sv
`timescale 1ns/1ps
module sim_cyc_seq_mem;
   localparam int N  = 4;
   localparam int M  = 4;
   localparam int DW = 8;
   localparam int W  = 2;
   localparam int D  = 2;
   localparam int G  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_in = 1'b0;
   logic          we_n = 1'b1;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic [N-1:0]  row_sel;
   logic [M-1:0]  col_sel;
   logic          last_row_out;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   typedef struct {
      logic [DW-1:0] v;
      string         tag;
   } exp_t;
   exp_t          exp_q[$];
   logic [DW-1:0] shadow [N*M];
   logic [DW-1:0] exp_dout = '0;

   always #4 clk = ~clk;

   cyc_seq_mem #(.ROWS(N), .COLS(M), .DW(DW), .RCD_WAIT(W), .COL_DIV(D), .REF_GAP(G)) u0 (
      .clk(clk), .rst_n(rst_n), .start_in(start_in), .we_n(we_n), .din(din),
      .dout(dout), .row_sel(row_sel), .col_sel(col_sel), .last_row_out(last_row_out)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Scoreboard monitor: compares dout with every expected item as it arrives.
   initial begin
      exp_t e;
      forever begin
         wait (exp_q.size() > 0);
         e = exp_q.pop_front();
         chk(dout === e.v, e.tag, int'(dout), int'(e.v));
      end
   end

   // Driver: entered at the first cycle of row 0, column 0.
   // mode 0 writes all, 1 reads all (with a stray start pulse), 2 checkerboard.
   task automatic sweep(input int mode, input int sno);
      for (int r = 0; r < N; r++) begin
         for (int c = 0; c < M; c++) begin
            logic [DW-1:0] val;
            bit            wr;
            exp_t          e;
            val = DW'((sno * 53 + r * 16 + c * 5 + 7) & 255);
            wr  = (mode == 0) || (mode == 2 && ((r + c) % 2 == 0));
            chk(int'(row_sel) == (1 << r), "R2", int'(row_sel), 1 << r);
            chk(int'(col_sel) == (1 << c), (c == 0) ? "R3" : "R4", int'(col_sel), 1 << c);
            we_n = !wr;
            din  = wr ? val : ~val;
            if (mode == 1 && r == 1 && c == 2) start_in = 1'b1; // R9 stray start
            wait_n(D - 1);
            chk(last_row_out == (r == N-1 && c == M-1), "R7", int'(last_row_out),
                int'(r == N-1 && c == M-1));
            wait_n(1);
            if (wr) begin
               shadow[r*M + c] = val;
               e.tag = "R5";
            end else begin
               exp_dout = shadow[r*M + c];
               e.tag = "R6";
            end
            e.v = exp_dout;
            exp_q.push_back(e);
            start_in = 1'b0;
            we_n     = 1'b1;
         end
         if (r < N-1) begin
            wait_n(1 + W);
         end else begin
            chk(row_sel == N'(1 << (N-1)) && col_sel == '0, "R8",
                int'({row_sel, col_sel}), (1 << (N-1)) << M);
            wait_n(2*G + W);
            chk(col_sel == '0 && row_sel == N'(1), "R8",
                int'({row_sel, col_sel}), 1 << M);
            wait_n(1);
         end
      end
   endtask

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      chk(row_sel == '0 && col_sel == '0, "R1", int'({row_sel, col_sel}), 0);
      chk(dout == '0 && !last_row_out, "R1", int'({last_row_out, dout}), 0);
      wait_n(8);
      chk(row_sel == '0 && col_sel == '0 && dout == '0, "R1",
          int'({row_sel, col_sel, dout}), 0);
      start_in = 1'b1;
      wait_n(1);
      start_in = 1'b0;
      wait_n(1 + W);
      sweep(0, 0);
      sweep(1, 1);
      sweep(2, 2);
      sweep(1, 3);
      wait_n(2);
      chk(exp_q.size() == 0, "R6", exp_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule